// File: doc/BRIEF.md
# Implicit Writeback Controller

This block is the response-side control logic of a memory controller that sits on a shared, snooped processor bus. It accepts one in-order transaction at a time, together with the snoop result sampled for it. If no agent reports a modified-line hit, the controller answers normally. If a snooper reports that it holds the line modified, the controller keeps ownership of the response but answers with an implicit-writeback code. In that case it runs up to two data handshakes in a fixed order: first the request's own write data, if any, and then the snooper's writeback of the line.

The controller paces both transfers with a single data-ready strobe. It waits for a free line buffer before it invites the writeback. It places the response exactly two cycles after the cycle in which data-ready is high and the data bus is idle. It then samples the data-busy signal in that response cycle to learn whether writeback data will follow. Request bytes and writeback bytes are merged in a four-chunk line buffer, and request bytes win on each lane they cover. Once all expected data has arrived, a single-cycle memory update carries the merged line, a byte mask and the address.

Top module: `iwb_ctrl`

## Requirements
- R1: A read that sees no modified hit gets a normal-data response in the cycle after it is accepted. It produces no data-ready pulse and no memory update.
- R2: A transaction that carries request write data drives data_ready high for exactly the one cycle after acceptance. Its data chunks then fill line chunks 0, 1, 2 and 3 in arrival order, one per dat_valid cycle, and the chunk with dat_last high ends the transfer.
- R3: rsp_code is 3'b001 for normal-data, 3'b010 for no-data (a write with no modified hit) and 3'b100 for implicit writeback (any modified hit). It is 3'b000 whenever rsp_valid is low.
- R4: On a modified hit, the snoop-side data_ready rises only in the cycle after buf_free is sampled high. It rises only after any request-side data_ready has been low for at least one cycle.
- R5: The snoop-side data_ready stays high while data_busy is high. It falls after the first cycle in which it is high with data_busy low.
- R6: For a modified hit, rsp_valid is high for one cycle, exactly two cycles after the cycle in which data_ready is high and data_busy is low.
- R7: data_busy is sampled in the implicit-writeback response cycle. If it is high, the block takes four writeback chunks, ending on dat_last, and ignores dat_be for them. If it is low, the block waits for no line data.
- R8: In the merged line, chunk c occupies mem_line bits [64c+63:64c], and lane b of chunk c is mem_be bit 8c+b. A lane written by the request keeps the request byte. Other lanes take the writeback byte. Lanes written by neither have mem_be clear and a data value of zero.
- R9: mem_write_req pulses for one cycle once all expected data has been taken, carrying the merged line and the accepted address. It does not pulse when no lane holds data.
- R10: txn_start is ignored while a transaction is in progress.
- R11: A synchronous reset, seen at a clock edge, leaves data_ready, rsp_valid and mem_write_req low in the following cycle and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txn_start | input | 1 | New transaction with its snoop result; taken only when idle |
| txn_addr | input | 32 | Line address of the transaction |
| txn_is_wr | input | 1 | Transaction carries request write data |
| txn_hitm | input | 1 | Snoop reported a modified-line hit |
| buf_free | input | 1 | A line buffer can take the writeback |
| data_busy | input | 1 | Data bus busy, driven by the transferring agent |
| dat_valid | input | 1 | A data chunk is present |
| dat_last | input | 1 | Marks the final chunk of a transfer |
| dat_be | input | 8 | Byte enables of a request chunk |
| dat_word | input | 64 | Data chunk |
| data_ready | output | 1 | Target ready for a data transfer |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | Encoded response |
| mem_write_req | output | 1 | One-cycle memory update strobe |
| mem_addr | output | 32 | Address of the update |
| mem_line | output | 256 | Merged line |
| mem_be | output | 32 | Byte mask of the merged line |

## Verification
A sequencer stuck in, or skipping, a waiting state shows at the ports within one cycle. It appears as data_ready high in a cycle where it should be low, or as a response shifted away from its two-cycle slot after the reference cycle. A wrong latched snoop or write flag changes rsp_code in the response cycle itself. Errors in the chunk counter or in lane priority stay hidden until the memory update, where a single misplaced byte shows up in mem_line or mem_be.

// File: rtl/iwb_pkg.sv
package iwb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ_RDY,
    ST_REQ_DATA,
    ST_SNP_WAIT,
    ST_SNP_RDY,
    ST_GAP,
    ST_RSP,
    ST_WB_DATA,
    ST_MEMW
  } iwb_state_e;

  localparam logic [2:0] RSP_NONE   = 3'b000;
  localparam logic [2:0] RSP_NORMAL = 3'b001;
  localparam logic [2:0] RSP_NODATA = 3'b010;
  localparam logic [2:0] RSP_IMPWB  = 3'b100;

  // A request byte may always land; a writeback byte only where the request left the lane empty.
  function automatic logic lane_writable(input logic lane_from_req, input logic src_is_req);
    return src_is_req | ~lane_from_req;
  endfunction

  function automatic logic [2:0] pick_code(input logic hit, input logic is_wr);
    if (hit)        return RSP_IMPWB;
    else if (is_wr) return RSP_NODATA;
    else            return RSP_NORMAL;
  endfunction

endpackage

// File: rtl/iwb_linebuf.sv
module iwb_linebuf #(
  parameter int CHUNK_W = 64,
  parameter int CHUNKS  = 4,
  localparam int BE_W   = CHUNK_W / 8,
  localparam int IDX_W  = $clog2(CHUNKS),
  localparam int LINE_B = CHUNKS * BE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic                 wr_from_req,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [BE_W-1:0]      wr_be,
  input  logic [CHUNK_W-1:0]   wr_word,
  output logic [LINE_B*8-1:0]  line,
  output logic [LINE_B-1:0]    line_be,
  output logic                 any_valid
);

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
      localparam int K = c * BE_W + b;
      logic [7:0] byte_q;
      logic       vld_q;
      logic       req_q;
      logic       hit;

      assign hit = wr_en && (wr_idx == IDX_W'(c)) && wr_be[b]
                   && iwb_pkg::lane_writable(req_q, wr_from_req);

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          byte_q <= '0;
          vld_q  <= 1'b0;
          req_q  <= 1'b0;
        end else if (hit) begin
          byte_q <= wr_word[b*8 +: 8];
          vld_q  <= 1'b1;
          req_q  <= req_q | wr_from_req;
        end
      end

      assign line[K*8 +: 8] = byte_q;
      assign line_be[K]     = vld_q;
    end
  end

  assign any_valid = |line_be;

endmodule

// File: rtl/iwb_seq.sv
module iwb_seq #(
  parameter int CHUNKS = 4,
  localparam int IDX_W = $clog2(CHUNKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txn_start,
  input  logic             txn_is_wr,
  input  logic             txn_hitm,
  input  logic             buf_free,
  input  logic             data_busy,
  input  logic             dat_valid,
  input  logic             dat_last,
  input  logic             any_valid,
  output logic             data_ready,
  output logic             rsp_valid,
  output logic [2:0]       rsp_code,
  output logic             mem_write_req,
  output logic             accept,
  output logic             buf_wr,
  output logic             buf_from_req,
  output logic [IDX_W-1:0] buf_idx,
  output logic             snp_rdy,
  output logic             ref_evt
);
  import iwb_pkg::*;

  iwb_state_e state_q, state_d;
  logic       wr_q, hit_q;
  logic [IDX_W-1:0] cnt_q;
  logic       req_phase, wb_phase, take_last;

  assign accept     = (state_q == ST_IDLE) && txn_start;
  assign req_phase  = (state_q == ST_REQ_RDY) || (state_q == ST_REQ_DATA);
  assign wb_phase   = (state_q == ST_WB_DATA);
  assign snp_rdy    = (state_q == ST_SNP_RDY);
  assign ref_evt    = snp_rdy && !data_busy;
  assign take_last  = dat_valid && dat_last;

  assign data_ready    = (state_q == ST_REQ_RDY) || snp_rdy;
  assign rsp_valid     = (state_q == ST_RSP);
  assign rsp_code      = rsp_valid ? pick_code(hit_q, wr_q) : RSP_NONE;
  assign mem_write_req = (state_q == ST_MEMW);

  assign buf_wr       = dat_valid && (req_phase || wb_phase);
  assign buf_from_req = req_phase;
  assign buf_idx      = cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (txn_start) begin
        if (txn_is_wr)     state_d = ST_REQ_RDY;
        else if (txn_hitm) state_d = ST_SNP_WAIT;
        else               state_d = ST_RSP;
      end
      ST_REQ_RDY, ST_REQ_DATA: begin
        if (take_last)     state_d = hit_q ? ST_SNP_WAIT : ST_RSP;
        else               state_d = ST_REQ_DATA;
      end
      ST_SNP_WAIT: if (buf_free)   state_d = ST_SNP_RDY;
      ST_SNP_RDY:  if (!data_busy) state_d = ST_GAP;
      ST_GAP:      state_d = ST_RSP;
      ST_RSP: begin
        if (hit_q && data_busy) state_d = ST_WB_DATA;
        else if (any_valid)     state_d = ST_MEMW;
        else                    state_d = ST_IDLE;
      end
      ST_WB_DATA: if (take_last) state_d = ST_MEMW;
      ST_MEMW:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      hit_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wr_q  <= txn_is_wr;
        hit_q <= txn_hitm;
        cnt_q <= '0;
      end else if (buf_wr) begin
        cnt_q <= dat_last ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/iwb_ctrl.sv
module iwb_ctrl #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 64,
  parameter int CHUNKS  = 4,
  localparam int BE_W   = CHUNK_W / 8,
  localparam int IDX_W  = $clog2(CHUNKS),
  localparam int LINE_B = CHUNKS * BE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                txn_start,
  input  logic [ADDR_W-1:0]   txn_addr,
  input  logic                txn_is_wr,
  input  logic                txn_hitm,
  input  logic                buf_free,
  input  logic                data_busy,
  input  logic                dat_valid,
  input  logic                dat_last,
  input  logic [BE_W-1:0]     dat_be,
  input  logic [CHUNK_W-1:0]  dat_word,
  output logic                data_ready,
  output logic                rsp_valid,
  output logic [2:0]          rsp_code,
  output logic                mem_write_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [LINE_B*8-1:0] mem_line,
  output logic [LINE_B-1:0]   mem_be
);

  logic             accept, buf_wr, buf_from_req, any_valid;
  logic             snp_rdy, ref_evt;
  logic [IDX_W-1:0] buf_idx;
  logic [BE_W-1:0]  wr_be;
  logic [ADDR_W-1:0] addr_q;

  iwb_seq #(.CHUNKS(CHUNKS)) u_seq (
    .clk(clk), .rst(rst),
    .txn_start(txn_start), .txn_is_wr(txn_is_wr), .txn_hitm(txn_hitm),
    .buf_free(buf_free), .data_busy(data_busy),
    .dat_valid(dat_valid), .dat_last(dat_last), .any_valid(any_valid),
    .data_ready(data_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .mem_write_req(mem_write_req), .accept(accept),
    .buf_wr(buf_wr), .buf_from_req(buf_from_req), .buf_idx(buf_idx),
    .snp_rdy(snp_rdy), .ref_evt(ref_evt)
  );

  // Writeback chunks always cover every lane.
  assign wr_be = buf_from_req ? dat_be : '1;

  iwb_linebuf #(.CHUNK_W(CHUNK_W), .CHUNKS(CHUNKS)) u_buf (
    .clk(clk), .rst(rst), .clr(accept),
    .wr_en(buf_wr), .wr_from_req(buf_from_req), .wr_idx(buf_idx),
    .wr_be(wr_be), .wr_word(dat_word),
    .line(mem_line), .line_be(mem_be), .any_valid(any_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (accept) addr_q <= txn_addr;
  end

  assign mem_addr = addr_q;

endmodule

// File: rtl/iwb_ctrl_chk.sv
module iwb_ctrl_chk #(
  parameter int LINE_B = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              data_ready,
  input logic              data_busy,
  input logic              buf_free,
  input logic              rsp_valid,
  input logic [2:0]        rsp_code,
  input logic              mem_write_req,
  input logic [LINE_B-1:0] mem_be,
  input logic              snp_rdy,
  input logic              ref_evt
);

  // R3
  code_shape_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid ? ($countones(rsp_code) == 1) : (rsp_code == 3'b000));

  // R4
  snp_after_free_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(snp_rdy) |-> ($past(buf_free) && !$past(data_ready)));

  // R5
  snp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_rdy && data_busy) |=> snp_rdy);

  // R6
  rsp_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ref_evt |-> ##2 (rsp_valid && rsp_code == 3'b100));

  // R6
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7
  wb_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 3'b100 && data_busy) |=> !mem_write_req);

  // R9
  memw_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_write_req |-> ((|mem_be) && !data_ready) ##1 !mem_write_req);

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!data_ready && !rsp_valid && !mem_write_req));

endmodule

bind iwb_ctrl iwb_ctrl_chk #(.LINE_B(LINE_B)) u_chk (
  .clk(clk), .rst(rst), .data_ready(data_ready), .data_busy(data_busy),
  .buf_free(buf_free), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .mem_write_req(mem_write_req), .mem_be(mem_be),
  .snp_rdy(snp_rdy), .ref_evt(ref_evt)
);

// File: tb/iwb_ctrl_bench.sv
module iwb_ctrl_bench;

  localparam logic [2:0] C_NORM = 3'b001;
  localparam logic [2:0] C_NOD  = 3'b010;
  localparam logic [2:0] C_IWB  = 3'b100;

  // {wr, hitm, wb_present, hold_busy, poke, dly[2:0], be[7:0]}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_0_0_0_0_000_00000000,
    16'b1_0_0_0_0_000_11111111,
    16'b0_1_1_1_0_010_00000000,
    16'b1_1_1_0_0_000_00001111,
    16'b1_1_0_0_0_001_11111111,
    16'b0_1_0_0_1_011_00000000,
    16'b1_0_0_0_0_000_00000000,
    16'b1_1_1_1_0_001_10100101
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         txn_start = 1'b0;
  logic [31:0]  txn_addr = '0;
  logic         txn_is_wr = 1'b0;
  logic         txn_hitm = 1'b0;
  logic         buf_free = 1'b0;
  logic         data_busy = 1'b0;
  logic         dat_valid = 1'b0;
  logic         dat_last = 1'b0;
  logic [7:0]   dat_be = '0;
  logic [63:0]  dat_word = '0;
  logic         data_ready, rsp_valid, mem_write_req;
  logic [2:0]   rsp_code;
  logic [31:0]  mem_addr;
  logic [255:0] mem_line;
  logic [31:0]  mem_be;

  int checks = 0;
  int fails  = 0;
  bit timeout = 1'b0;

  always #4 clk = ~clk;

  iwb_ctrl u_iwb_ctrl (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_addr(txn_addr),
    .txn_is_wr(txn_is_wr), .txn_hitm(txn_hitm), .buf_free(buf_free),
    .data_busy(data_busy), .dat_valid(dat_valid), .dat_last(dat_last),
    .dat_be(dat_be), .dat_word(dat_word), .data_ready(data_ready),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_write_req(mem_write_req),
    .mem_addr(mem_addr), .mem_line(mem_line), .mem_be(mem_be)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] req_word(input int c);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[b*8 +: 8] = 8'(8'h80 + c*16 + b);
    return w;
  endfunction

  function automatic logic [63:0] wb_word(input int c);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[b*8 +: 8] = 8'(8'h40 + c*16 + b);
    return w;
  endfunction

  task automatic send_chunks(input logic [7:0] be, input bit from_req);
    for (int c = 0; c < 4; c++) begin
      dat_valid = 1'b1;
      dat_last  = (c == 3);
      dat_be    = be;
      dat_word  = from_req ? req_word(c) : wb_word(c);
      @(negedge clk);
      if (from_req && c == 0) check(data_ready == 1'b0, "R2 ready one cycle", data_ready, 0);
    end
    dat_valid = 1'b0;
    dat_last  = 1'b0;
  endtask

  task automatic run_txn(input logic [15:0] v, input logic [31:0] addr);
    bit wr, hit, wbp, hold, poke;
    int dly;
    logic [255:0] exp_line;
    logic [31:0]  exp_be;
    wr = v[15]; hit = v[14]; wbp = v[13]; hold = v[12]; poke = v[11];
    dly = int'(v[10:8]);

    @(negedge clk);
    txn_start = 1'b1; txn_addr = addr; txn_is_wr = wr; txn_hitm = hit;
    @(negedge clk);
    txn_start = 1'b0;

    if (wr) begin
      check(data_ready == 1'b1, "R2 request ready", data_ready, 1);
      send_chunks(v[7:0], 1'b1);
    end

    if (hit) begin
      for (int k = 0; k < dly; k++) begin
        check(data_ready == 1'b0, "R4 wait for buffer", data_ready, 0);
        if (poke && k == 0) begin
          txn_start = 1'b1; txn_is_wr = 1'b0; txn_hitm = 1'b0; // R10
        end
        @(negedge clk);
        txn_start = 1'b0;
      end
      buf_free = 1'b1;
      @(negedge clk);
      buf_free = 1'b0;
      check(data_ready == 1'b1, "R4 snoop ready", data_ready, 1);
      if (hold) begin
        data_busy = 1'b1;
        @(negedge clk);
        check(data_ready == 1'b1, "R5 held while busy", data_ready, 1);
        data_busy = 1'b0;
      end
      @(negedge clk);
      check(data_ready == 1'b0, "R5 ready drops", data_ready, 0);
      check(rsp_valid == 1'b0, "R6 no early response", rsp_valid, 0);
      data_busy = wbp;
      @(negedge clk);
      check(rsp_valid == 1'b1 && rsp_code == C_IWB, "R6 R3 writeback response",
            {rsp_valid, rsp_code}, {1'b1, C_IWB});
      @(negedge clk);
      if (wbp) begin
        check(mem_write_req == 1'b0, "R7 waits for line", mem_write_req, 0);
        send_chunks(8'h00, 1'b0);
        data_busy = 1'b0;
      end
    end else begin
      check(rsp_valid == 1'b1 && rsp_code == (wr ? C_NOD : C_NORM), "R1 R3 plain response",
            {rsp_valid, rsp_code}, {1'b1, (wr ? C_NOD : C_NORM)});
      if (!wr) check(data_ready == 1'b0, "R1 no ready", data_ready, 0);
      @(negedge clk);
    end

    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < 8; b++) begin
        if (wr && v[b]) begin
          exp_line[(c*8+b)*8 +: 8] = req_word(c)[b*8 +: 8];
          exp_be[c*8+b] = 1'b1;
        end else if (hit && wbp) begin
          exp_line[(c*8+b)*8 +: 8] = wb_word(c)[b*8 +: 8];
          exp_be[c*8+b] = 1'b1;
        end else begin
          exp_line[(c*8+b)*8 +: 8] = 8'h00;
          exp_be[c*8+b] = 1'b0;
        end
      end
    end

    check(rsp_valid == 1'b0, "R6 response one cycle", rsp_valid, 0);
    check(mem_write_req == (|exp_be), "R9 update strobe", mem_write_req, |exp_be);
    if (|exp_be) begin
      check(mem_line == exp_line, "R8 merged line", mem_line, exp_line);
      check(mem_be == exp_be, "R8 byte mask", mem_be, exp_be);
      check(mem_addr == addr, "R9 address", mem_addr, addr);
    end
    @(negedge clk);
    check(mem_write_req == 1'b0, "R9 single pulse", mem_write_req, 0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(data_ready == 1'b0, "R11 reset ready", data_ready, 0);
    check(rsp_valid == 1'b0 && rsp_code == 3'b000, "R11 R3 reset response", {rsp_valid, rsp_code}, 0);
    check(mem_write_req == 1'b0, "R11 reset update", mem_write_req, 0);

    for (int i = 0; i < NV; i++) run_txn(VEC[i], 32'h1000_0000 + 32'(i) * 32'h40);

    // R11: reset in the middle of a snoop handshake
    @(negedge clk);
    txn_start = 1'b1; txn_is_wr = 1'b0; txn_hitm = 1'b1; txn_addr = 32'hBEEF_0000;
    @(negedge clk);
    txn_start = 1'b0; buf_free = 1'b1;
    @(negedge clk);
    buf_free = 1'b0; data_busy = 1'b1;
    check(data_ready == 1'b1, "R4 ready before reset", data_ready, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; data_busy = 1'b0;
    check(data_ready == 1'b0 && rsp_valid == 1'b0 && mem_write_req == 1'b0, "R11 mid reset",
          {data_ready, rsp_valid, mem_write_req}, 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 no stale response", rsp_valid, 0);
    run_txn(VEC[0], 32'h2000_0000);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule